// File: doc/BRIEF.md
# ATA PIO Host Command Sequencer

This block sits on the host side of a parallel disk interface. It runs one multi-sector read or write by programmed I/O through the device's task-file registers. A command port takes a direction, a 28-bit logical block address, a drive select and a sector count. The block then drives a simple register bus with a 10-bit address, single-cycle read and write strobes and 16-bit data. It waits for the device to become idle and ready. It loads the block address and count, issues the command, and moves each sector's words only while the device requests data. It ends with a one-cycle done or error pulse.

After reset the block pulses the soft-reset bit of the device control register and then leaves device interrupts enabled. Read data leaves on an output valid/ready stream, and write data arrives on an input valid/ready stream. Failures are classified in a small error-kind code. A device-reported error also returns the device's 8-bit error register, whose bits from 7 down to 0 mean bad block, uncorrectable data, media changed, ID not found, media change requested, aborted command, track 0 not found and address mark not found.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset the block writes 0x0C and then 0x08 to control address 0x3F6 on two consecutive cycles; cmd_ready rises only after that.
- R2: After a command is accepted and before any parameter write, the block reads status at 0x1F7 until BUSY (bit 7) is 0 and READY (bit 6) is 1, one read per poll.
- R3: The parameter writes fall on consecutive cycles in this order: 0x1F2 sector count, 0x1F3 LBA[7:0], 0x1F4 LBA[15:8], 0x1F5 LBA[23:16], 0x1F6 = {1,1,1,drive,LBA[27:24]}. The very next cycle writes the command code to 0x1F7: 0x20 for a read, 0x30 for a write.
- R4: Before each sector the block polls status until READY, DRQ (bit 3) and not BUSY, and then moves exactly SECTOR_WORDS (default 256) words through data port 0x1F0.
- R5: On a read, each word read from 0x1F0 appears in order on rd_data with rd_valid, and is held stable until rd_ready is high.
- R6: On a write, each word accepted on wr_data (wr_valid with wr_ready) is written to 0x1F0 in the same cycle, in order.
- R7: After the last word of the last sector, done is high for exactly one cycle with err_kind 0, and the block returns to idle.
- R8: An ERROR status bit (bit 0) with BUSY clear during a data poll makes the block read 0x1F1. err then pulses with err_kind 2, and err_code holds the low 8 bits of that read.
- R9: A FAULT status bit (bit 5) seen in any poll ends the command with err and err_kind 3, with no further register write.
- R10: POLL_LIMIT consecutive unsatisfied status reads end the command with err and err_kind 4.
- R11: A command with sector count 0 is accepted, touches no register, and gives err with err_kind 1 in the cycle after acceptance.
- R12: done and err are never high together, and bus_rd and bus_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command taken when both high |
| cmd_write | input | 1 | 1 = write to disk, 0 = read |
| cmd_drive | input | 1 | Drive select |
| cmd_lba | input | 28 | Logical block address |
| cmd_count | input | 8 | Sector count, 0 is rejected |
| bus_addr | output | 10 | Register address |
| bus_rd | output | 1 | Read strobe, data returned next cycle |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid the cycle after bus_rd |
| rd_data | output | 16 | Read stream word |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| wr_data | input | 16 | Write stream word |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_kind | output | 3 | 0 none, 1 bad count, 2 device error, 3 fault, 4 timeout |
| err_code | output | 8 | Device error register value for err_kind 2 |

## Verification
The stream handshake on the final word of a sector and the choice between re-polling and finishing fall in the same cycle. A wrong choice either adds or drops a status poll, or raises done too early. This is provoked by multi-sector commands under throttled rd_ready and gapped wr_valid patterns, with the device held busy for a varying number of polls between sectors. It is judged by comparing the exact count of status reads with the count the busy settings predict, together with the word count and the data order.

// File: rtl/ata_pio_seq.sv
module ata_pio_seq #(
  parameter int SECTOR_WORDS = 256,
  parameter int POLL_LIMIT   = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_write,
  input  logic        cmd_drive,
  input  logic [27:0] cmd_lba,
  input  logic [7:0]  cmd_count,
  output logic [9:0]  bus_addr,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  input  logic [15:0] wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic        done,
  output logic        err,
  output logic [2:0]  err_kind,
  output logic [7:0]  err_code
);
  localparam int WW = $clog2(SECTOR_WORDS);
  localparam int PW = $clog2(POLL_LIMIT);
  localparam logic [9:0] A_DATA = 10'h1F0, A_ERR = 10'h1F1, A_CNT = 10'h1F2,
                         A_DRV = 10'h1F6, A_CMD = 10'h1F7, A_CTL = 10'h3F6;
  localparam logic [2:0] K_NONE = 3'd0, K_ARG = 3'd1, K_DEV = 3'd2, K_FLT = 3'd3, K_TMO = 3'd4;

  typedef enum logic [3:0] {
    S_INIT_R, S_INIT_E, S_IDLE, S_POLL, S_STAT, S_PARM, S_CMD,
    S_RSTB, S_RCAP, S_ROUT, S_WDAT, S_ERRA, S_ERRC, S_DONE, S_FAIL
  } st_t;

  st_t           st;
  logic          wmode, drv, ph_drq;
  logic [27:0]   lba;
  logic [7:0]    cnt, sec_left;
  logic [2:0]    pidx;
  logic [WW-1:0] wcnt;
  logic [PW-1:0] pcnt;
  logic [15:0]   rd_q;
  logic [7:0]    pdata;

  wire s_busy = bus_rdata[7];
  wire s_rdy  = bus_rdata[6];
  wire s_flt  = bus_rdata[5];
  wire s_drq  = bus_rdata[3];
  wire s_err  = bus_rdata[0];
  wire word_fire = (st == S_ROUT && rd_ready) || (st == S_WDAT && wr_valid);
  wire last_word = (wcnt == WW'(SECTOR_WORDS - 1));

  assign cmd_ready = (st == S_IDLE);
  assign rd_valid  = (st == S_ROUT);
  assign rd_data   = rd_q;
  assign wr_ready  = (st == S_WDAT);
  assign done      = (st == S_DONE);
  assign err       = (st == S_FAIL);

  always_comb begin
    case (pidx)
      3'd0:    pdata = cnt;
      3'd1:    pdata = lba[7:0];
      3'd2:    pdata = lba[15:8];
      3'd3:    pdata = lba[23:16];
      default: pdata = {3'b111, drv, lba[27:24]};
    endcase
  end

  always_comb begin
    bus_addr = A_DATA; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 16'h0;
    case (st)
      S_INIT_R: begin bus_addr = A_CTL; bus_wr = 1'b1; bus_wdata = 16'h000C; end
      S_INIT_E: begin bus_addr = A_CTL; bus_wr = 1'b1; bus_wdata = 16'h0008; end
      S_POLL:   begin bus_addr = A_CMD; bus_rd = 1'b1; end
      S_PARM:   begin bus_addr = A_CNT + {7'd0, pidx}; bus_wr = 1'b1; bus_wdata = {8'h00, pdata}; end
      S_CMD:    begin bus_addr = A_CMD; bus_wr = 1'b1; bus_wdata = wmode ? 16'h0030 : 16'h0020; end
      S_RSTB:   bus_rd = 1'b1;
      S_WDAT:   begin bus_wr = wr_valid; bus_wdata = wr_data; end
      S_ERRA:   begin bus_addr = A_ERR; bus_rd = 1'b1; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_INIT_R; wmode <= 1'b0; drv <= 1'b0; ph_drq <= 1'b0;
      lba <= '0; cnt <= '0; sec_left <= '0; pidx <= '0; wcnt <= '0; pcnt <= '0;
      rd_q <= '0; err_kind <= K_NONE; err_code <= '0;
    end else begin
      case (st)
        S_INIT_R: st <= S_INIT_E;
        S_INIT_E: st <= S_IDLE;
        S_IDLE: if (cmd_valid) begin
          wmode <= cmd_write; drv <= cmd_drive; lba <= cmd_lba; cnt <= cmd_count;
          sec_left <= cmd_count; err_kind <= K_NONE; err_code <= '0;
          pcnt <= '0; ph_drq <= 1'b0; wcnt <= '0;
          if (cmd_count == 8'd0) begin err_kind <= K_ARG; st <= S_FAIL; end
          else st <= S_POLL;
        end
        S_POLL: st <= S_STAT;
        S_STAT: begin
          if (s_flt) begin err_kind <= K_FLT; st <= S_FAIL; end
          else if (ph_drq && !s_busy && s_err) st <= S_ERRA;
          else if (!ph_drq && !s_busy && s_rdy) begin pidx <= '0; st <= S_PARM; end
          else if (ph_drq && !s_busy && s_rdy && s_drq) st <= wmode ? S_WDAT : S_RSTB;
          else if (pcnt == PW'(POLL_LIMIT - 1)) begin err_kind <= K_TMO; st <= S_FAIL; end
          else begin pcnt <= pcnt + 1'b1; st <= S_POLL; end
        end
        S_PARM: begin
          if (pidx == 3'd4) st <= S_CMD;
          pidx <= pidx + 1'b1;
        end
        S_CMD: begin ph_drq <= 1'b1; pcnt <= '0; wcnt <= '0; st <= S_POLL; end
        S_RSTB: st <= S_RCAP;
        S_RCAP: begin rd_q <= bus_rdata; st <= S_ROUT; end
        S_ERRA: st <= S_ERRC;
        S_ERRC: begin err_code <= bus_rdata[7:0]; err_kind <= K_DEV; st <= S_FAIL; end
        S_DONE, S_FAIL: st <= S_IDLE;
        default: ;
      endcase
      if (word_fire) begin
        if (last_word) begin
          wcnt <= '0;
          if (sec_left == 8'd1) st <= S_DONE;
          else begin sec_left <= sec_left - 1'b1; pcnt <= '0; st <= S_POLL; end
        end else begin
          wcnt <= wcnt + 1'b1;
          st <= wmode ? S_WDAT : S_RSTB;
        end
      end
    end
  end

  // R12
  no_rdwr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr));
  // R12
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R3
  cmd_after_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CMD) |-> $past(bus_wr && bus_addr == A_DRV));
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_rd && !bus_wr));
endmodule

// File: tb/ata_pio_seq_tb.sv
module ata_pio_seq_tb;
  localparam int PL = 20;
  localparam int SW = 256;
  // {write, drive, count[8], pre_busy[4], mid_busy[4], lba[28]}
  localparam logic [45:0] VEC [4] = '{
    {1'b0, 1'b0, 8'd1, 4'd0, 4'd0, 28'h1234567},
    {1'b1, 1'b1, 8'd2, 4'd3, 4'd2, 28'hABCDEF0},
    {1'b0, 1'b1, 8'd2, 4'd1, 4'd3, 28'hFFFFFFF},
    {1'b1, 1'b0, 8'd1, 4'd2, 4'd0, 28'h0000001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_drive = 1'b0;
  logic [27:0] cmd_lba = '0;
  logic [7:0] cmd_count = '0;
  logic cmd_ready, bus_rd, bus_wr, rd_valid, wr_ready, done, err;
  logic [9:0] bus_addr;
  logic [15:0] bus_wdata, rd_data;
  logic [15:0] bus_rdata = '0;
  logic rd_ready = 1'b0, wr_valid = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0] err_kind;
  logic [7:0] err_code;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int dev_mode = 0, pre_left = 0, mid_left = 0, mid_cfg = 0;
  bit cmd_seen = 0;
  int wsec = 0, st_reads = 0, st_pre = 0, dat_rd = 0, dat_wr = 0, wr_mism = 0, er_reads = 0;
  int rcv = 0, rd_mism = 0, wr_idx = 0, n_done = 0, first_par = -1;
  logic [9:0] lg_a [16];
  logic [7:0] lg_d [16];
  int lg_t [16];
  int lg_n = 0;

  ata_pio_seq #(.SECTOR_WORDS(SW), .POLL_LIMIT(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_drive(cmd_drive), .cmd_lba(cmd_lba), .cmd_count(cmd_count),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .done(done), .err(err),
    .err_kind(err_kind), .err_code(err_code));

  always #2 clk = ~clk;

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h0123) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] status_now();
    if (dev_mode == 3) return 16'h0080;
    if (dev_mode == 1) return 16'h0060;
    if (!cmd_seen) begin
      if (pre_left > 0) begin pre_left--; return 16'h0080; end
      return 16'h0040;
    end
    if (dev_mode == 2) return 16'h0041;
    if (mid_left > 0) begin mid_left--; return 16'h0080; end
    return 16'h0048;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (bus_rd) begin
        if (bus_addr == 10'h1F7) begin
          st_reads++; if (!cmd_seen) st_pre++;
          bus_rdata <= status_now();
        end else if (bus_addr == 10'h1F0) begin
          bus_rdata <= pat(dat_rd); dat_rd++; wsec++;
          if (wsec == SW) begin wsec = 0; mid_left = mid_cfg; end
        end else if (bus_addr == 10'h1F1) begin
          er_reads++; bus_rdata <= 16'h5A84;
        end
      end
      if (bus_wr) begin
        if (bus_addr == 10'h1F0) begin
          if (bus_wdata !== pat(dat_wr)) wr_mism++;
          dat_wr++; wsec++;
          if (wsec == SW) begin wsec = 0; mid_left = mid_cfg; end
        end else if (lg_n < 16) begin
          if (first_par < 0 && bus_addr == 10'h1F2) first_par = st_reads;
          lg_a[lg_n] = bus_addr; lg_d[lg_n] = bus_wdata[7:0]; lg_t[lg_n] = cyc; lg_n++;
          if (bus_addr == 10'h1F7) begin cmd_seen = 1; mid_left = mid_cfg; end
        end
      end
      if (rd_valid && rd_ready) begin
        if (rd_data !== pat(rcv)) rd_mism++;
        rcv++;
      end
      if (wr_valid && wr_ready) wr_idx++;
      if (done) n_done++;
    end
  end

  always @(negedge clk) begin
    rd_ready <= (cyc % 3 != 0);
    wr_data  <= pat(wr_idx);
    wr_valid <= wr_en && (cyc % 4 != 2);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic start(input bit w, input bit d, input logic [7:0] c, input logic [27:0] a,
                       input int pre, input int mid, input int mode);
    dev_mode = mode; pre_left = pre; mid_cfg = mid; mid_left = mid; cmd_seen = 0;
    wsec = 0; st_reads = 0; st_pre = 0; dat_rd = 0; dat_wr = 0; wr_mism = 0; er_reads = 0;
    rcv = 0; rd_mism = 0; wr_idx = 0; n_done = 0; first_par = -1; lg_n = 0;
    @(negedge clk);
    cmd_write = w; cmd_drive = d; cmd_count = c; cmd_lba = a; cmd_valid = 1'b1; wr_en = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_wait();
    int n = 0;
    while (!done && !err && n < 60000) begin @(negedge clk); n++; end
    chk(!(done && err), "R12", {done, err}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready == 0 && done == 0 && err == 0 && rd_valid == 0, "R1 reset", cmd_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(lg_n == 2 && lg_a[0] == 10'h3F6 && lg_d[0] == 8'h0C, "R1 first ctl", lg_d[0], 8'h0C);
    chk(lg_a[1] == 10'h3F6 && lg_d[1] == 8'h08 && lg_t[1] == lg_t[0] + 1, "R1 second ctl", lg_d[1], 8'h08);
    chk(cmd_ready == 1, "R1 ready", cmd_ready, 1);

    for (int v = 0; v < 4; v++) begin
      automatic logic w = VEC[v][45];
      automatic logic d = VEC[v][44];
      automatic logic [7:0] c = VEC[v][43:36];
      automatic int pre = int'(VEC[v][35:32]);
      automatic int mid = int'(VEC[v][31:28]);
      automatic logic [27:0] a = VEC[v][27:0];
      automatic int nw = int'(c) * SW;
      automatic logic [7:0] exp_d [6];
      exp_d = '{c, a[7:0], a[15:8], a[23:16], {3'b111, d, a[27:24]}, w ? 8'h30 : 8'h20};
      start(w, d, c, a, pre, mid, 0);
      finish_wait();
      chk(done == 1 && err_kind == 0, "R7 done", {done, err_kind}, 8);
      @(negedge clk);
      chk(done == 0 && cmd_ready == 1 && n_done == 1, "R7 pulse", n_done, 1);
      chk(first_par == pre + 1 && st_pre == pre + 1, "R2 ready poll", first_par, pre + 1);
      chk(lg_n == 6, "R3 write count", lg_n, 6);
      for (int k = 0; k < 6; k++) begin
        chk(lg_a[k] == 10'h1F2 + 10'(k) - (k == 5 ? 10'd1 : 10'd0) + (k == 5 ? 10'd1 : 10'd0)
            && lg_d[k] == exp_d[k] && (k == 0 || lg_t[k] == lg_t[k-1] + 1),
            "R3 param order", lg_d[k], exp_d[k]);
      end
      chk(st_reads == (pre + 1) + int'(c) * (mid + 1), "R4 drq polls", st_reads, (pre + 1) + int'(c) * (mid + 1));
      if (w) begin
        chk(dat_wr == nw && dat_rd == 0, "R4 word count", dat_wr, nw);
        chk(wr_mism == 0 && wr_idx == nw, "R6 write data", wr_mism, 0);
      end else begin
        chk(dat_rd == nw && rcv == nw, "R4 word count", rcv, nw);
        chk(rd_mism == 0, "R5 read data", rd_mism, 0);
      end
      wr_en = 1'b0;
    end

    start(1'b0, 1'b0, 8'd1, 28'h0000042, 0, 1, 2);
    finish_wait();
    chk(err == 1 && err_kind == 3'd2, "R8 kind", err_kind, 2);
    chk(err_code == 8'h84 && er_reads == 1 && dat_rd == 0, "R8 code", err_code, 8'h84);

    start(1'b1, 1'b1, 8'd3, 28'h0000100, 0, 0, 1);
    finish_wait();
    chk(err == 1 && err_kind == 3'd3, "R9 kind", err_kind, 3);
    chk(lg_n == 0 && dat_wr == 0, "R9 no writes", lg_n, 0);

    start(1'b0, 1'b0, 8'd1, 28'h0000200, 0, 0, 3);
    finish_wait();
    chk(err == 1 && err_kind == 3'd4, "R10 kind", err_kind, 4);
    chk(st_reads == PL, "R10 poll count", st_reads, PL);

    start(1'b0, 1'b0, 8'd0, 28'h0000300, 0, 0, 0);
    chk(err == 1 && err_kind == 3'd1, "R11 reject", err_kind, 1);
    @(negedge clk);
    chk(err == 0 && cmd_ready == 1 && lg_n == 0 && st_reads == 0, "R11 no access", lg_n + st_reads, 0);

    summary();
  end
endmodule